// File: doc/BRIEF.md
# Paired-Precision Floating-Point Register Bank

This block stores the operand registers of a floating-point unit. It holds thirty-two 32-bit words. Each word can be reached on its own as a single-precision register. Adjacent even/odd words can also be reached together as one of sixteen 64-bit double-precision registers. Two asynchronous read ports and one clocked write port each carry their own precision select. Writes and reads in the two precisions therefore see the same storage.

Next to the data words, the bank keeps the unit's control state:

- a 1-bit comparison result flag;
- a 5-bit field of accumulated IEEE exception flags, which only gains bits until it is explicitly cleared;
- a 2-bit rounding-direction field.

Each of these has its own write enable. An execution pipeline reads operands combinationally in its decode or issue stage and writes results back on a clock edge.

Top module: `fpreg_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all 32 words, the condition flag, the exception flags and the rounding field are set to zero.
- R2: A single-precision write (`wr_en`=1, `wr_dbl`=0) stores `wr_data[31:0]` into the word at `wr_addr` and leaves every other word unchanged.
- R3: A single-precision read (`rd?_dbl`=0) returns the addressed word on bits 31:0 of the read bus, with bits 63:32 equal to zero.
- R4: A double-precision read (`rd?_dbl`=1) with address bits 4:1 equal to k returns word 2k+1 on bits 63:32 and word 2k on bits 31:0. Address bit 0 has no effect.
- R5: A double-precision write with address bits 4:1 equal to k stores `wr_data[31:0]` into word 2k and `wr_data[63:32]` into word 2k+1 at the same edge. Address bit 0 has no effect, and all other words are unchanged.
- R6: Reads are combinational and are not forwarded from the write port. During a write cycle, a read of the target still returns the old value; the new value appears after the rising edge.
- R7: The two read ports are independent. Each returns its own address and precision in the same cycle.
- R8: The condition flag loads `cc_wdata` on an edge where `cc_we`=1 and holds otherwise.
- R9: With `flg_clr`=0, an edge with `flg_we`=1 makes the exception flags the bitwise OR of their old value and `flg_wdata`. With `flg_we`=0 they hold.
- R10: An edge with `flg_clr`=1 zeroes the old exception flags before any merge. So clear alone gives 0, and clear together with `flg_we`=1 gives exactly `flg_wdata`.
- R11: The rounding field loads `rm_wdata` on an edge where `rm_we`=1 and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rda_addr | input | 5 | Read port A word address |
| rda_dbl | input | 1 | Read port A precision: 1 = double |
| rda_data | output | 64 | Read port A data |
| rdb_addr | input | 5 | Read port B word address |
| rdb_dbl | input | 1 | Read port B precision: 1 = double |
| rdb_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 5 | Write port word address |
| wr_dbl | input | 1 | Write port precision: 1 = double |
| wr_data | input | 64 | Write data; single writes use bits 31:0 |
| cc_we | input | 1 | Condition flag write enable |
| cc_wdata | input | 1 | Condition flag new value |
| cc_q | output | 1 | Condition flag |
| flg_we | input | 1 | Exception flag merge enable |
| flg_clr | input | 1 | Exception flag clear strobe |
| flg_wdata | input | 5 | Exception flags to merge |
| flg_q | output | 5 | Accumulated exception flags |
| rm_we | input | 1 | Rounding field write enable |
| rm_wdata | input | 2 | Rounding field new value |
| rm_q | output | 2 | Rounding field |

## Verification
The bench sweeps every word and every pair, in both precisions and on both ports, against a word array it keeps itself.

- Double accesses are issued with address bit 0 set. A bank that honoured that bit would read or write a shifted pair.
- A swapped half order would put the even word on the high bits, which the distinct per-word patterns expose.
- After each single write, the neighbour word is checked to catch a write that spills into its pair partner.
- A bank that forwarded write data would already show the new value during the write cycle.
- The flag field is driven through merge, hold, clear, and clear-with-merge. A bank that overwrote instead of merging would lose earlier bits, and one that gave clear the wrong priority would keep stale flags.

// File: rtl/fpreg_pkg.sv
// Shared definitions for the paired-precision register bank.
// Assumes the word count is even so that every word has a pair partner.
package fpreg_pkg;

    // Access precision carried by each port's select line.
    typedef enum logic {
        PREC_SGL = 1'b0,
        PREC_DBL = 1'b1
    } prec_e;

    // Compute the even member of a pair from any word address.
    function automatic logic [4:0] pair_even(input logic [4:0] addr);
        return {addr[4:1], 1'b0};
    endfunction

endpackage

// File: rtl/fpreg_store.sv
// Word storage with pair-aware write decode.
// Each word has its own enable and data source. A double write loads both
// words of the addressed pair, odd word from the high half. A single write
// loads only the addressed word from the low half.
// Assumes NUM_W is even and AW = $clog2(NUM_W).
module fpreg_store #(
    parameter int NUM_W = 32,
    parameter int W     = 32,
    parameter int AW    = $clog2(NUM_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_dbl,
    input  logic [2*W-1:0]  wr_data,
    output logic [W-1:0]    words [NUM_W]
);
    import fpreg_pkg::*;

    prec_e wr_prec;

    // Map the raw precision bit to the shared enum.
    always_comb begin
        wr_prec = wr_dbl ? PREC_DBL : PREC_SGL;
    end

    for (genvar i = 0; i < NUM_W; i++) begin : g_word
        localparam logic [AW-1:0] IDX = AW'(i);
        logic          hit;
        logic [W-1:0]  din;

        // Decide whether this word is a target of the current write.
        always_comb begin
            if (wr_prec == PREC_DBL) begin
                hit = wr_en && (wr_addr[AW-1:1] == IDX[AW-1:1]);
            end else begin
                hit = wr_en && (wr_addr == IDX);
            end
        end

        // Odd words take the high half on double writes.
        always_comb begin
            if (IDX[0] && (wr_prec == PREC_DBL)) begin
                din = wr_data[2*W-1:W];
            end else begin
                din = wr_data[W-1:0];
            end
        end

        // Word register with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[i] <= '0;
            end else if (hit) begin
                words[i] <= din;
            end
        end
    end

endmodule

// File: rtl/fpreg_rport.sv
// Combinational read port.
// In single precision the addressed word is zero-extended into the low half
// of the bus. In double precision the pair is returned odd:even, ignoring
// the address LSB. No forwarding from the write port.
module fpreg_rport #(
    parameter int NUM_W = 32,
    parameter int W     = 32,
    parameter int AW    = $clog2(NUM_W)
) (
    input  logic [W-1:0]    words [NUM_W],
    input  logic [AW-1:0]   addr,
    input  logic            dbl,
    output logic [2*W-1:0]  data
);
    logic [AW-1:0] even_idx;
    logic [AW-1:0] odd_idx;

    // Derive both pair members from the request address.
    always_comb begin
        even_idx = {addr[AW-1:1], 1'b0};
        odd_idx  = {addr[AW-1:1], 1'b1};
    end

    // Select the bus layout according to precision.
    always_comb begin
        if (dbl) begin
            data = {words[odd_idx], words[even_idx]};
        end else begin
            data = {{W{1'b0}}, words[addr]};
        end
    end

endmodule

// File: rtl/fpreg_ctl.sv
// Floating-point control state: condition flag, sticky exception flags and
// rounding field. The clear strobe removes old flags before new ones merge,
// so clear with merge leaves exactly the incoming flags.
module fpreg_ctl #(
    parameter int FLAG_W = 5,
    parameter int RM_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cc_we,
    input  logic              cc_wdata,
    output logic              cc_q,
    input  logic              flg_we,
    input  logic              flg_clr,
    input  logic [FLAG_W-1:0] flg_wdata,
    output logic [FLAG_W-1:0] flg_q,
    input  logic              rm_we,
    input  logic [RM_W-1:0]   rm_wdata,
    output logic [RM_W-1:0]   rm_q
);
    logic [FLAG_W-1:0] flg_base;
    logic [FLAG_W-1:0] flg_add;

    // Form the next flag value from the retained part and the merged part.
    always_comb begin
        flg_base = flg_clr ? '0 : flg_q;
        flg_add  = flg_we ? flg_wdata : '0;
    end

    // Condition flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= 1'b0;
        end else if (cc_we) begin
            cc_q <= cc_wdata;
        end
    end

    // Sticky exception flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_base | flg_add;
        end
    end

    // Rounding field register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rm_q <= '0;
        end else if (rm_we) begin
            rm_q <= rm_wdata;
        end
    end

endmodule

// File: rtl/fpreg_bank.sv
// Top of the paired-precision register bank: storage, two read ports and
// the control-state registers. Assumes NUM_W even; read buses are 2*W wide.
module fpreg_bank #(
    parameter int NUM_W  = 32,
    parameter int W      = 32,
    parameter int FLAG_W = 5,
    parameter int RM_W   = 2,
    localparam int AW    = $clog2(NUM_W),
    localparam int DW    = 2 * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rda_addr,
    input  logic              rda_dbl,
    output logic [DW-1:0]     rda_data,
    input  logic [AW-1:0]     rdb_addr,
    input  logic              rdb_dbl,
    output logic [DW-1:0]     rdb_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic              wr_dbl,
    input  logic [DW-1:0]     wr_data,
    input  logic              cc_we,
    input  logic              cc_wdata,
    output logic              cc_q,
    input  logic              flg_we,
    input  logic              flg_clr,
    input  logic [FLAG_W-1:0] flg_wdata,
    output logic [FLAG_W-1:0] flg_q,
    input  logic              rm_we,
    input  logic [RM_W-1:0]   rm_wdata,
    output logic [RM_W-1:0]   rm_q
);
    logic [W-1:0] words [NUM_W];

    fpreg_store #(.NUM_W(NUM_W), .W(W), .AW(AW)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_dbl  (wr_dbl),
        .wr_data (wr_data),
        .words   (words)
    );

    fpreg_rport #(.NUM_W(NUM_W), .W(W), .AW(AW)) rport_a_i (
        .words (words),
        .addr  (rda_addr),
        .dbl   (rda_dbl),
        .data  (rda_data)
    );

    fpreg_rport #(.NUM_W(NUM_W), .W(W), .AW(AW)) rport_b_i (
        .words (words),
        .addr  (rdb_addr),
        .dbl   (rdb_dbl),
        .data  (rdb_data)
    );

    fpreg_ctl #(.FLAG_W(FLAG_W), .RM_W(RM_W)) ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cc_we     (cc_we),
        .cc_wdata  (cc_wdata),
        .cc_q      (cc_q),
        .flg_we    (flg_we),
        .flg_clr   (flg_clr),
        .flg_wdata (flg_wdata),
        .flg_q     (flg_q),
        .rm_we     (rm_we),
        .rm_wdata  (rm_wdata),
        .rm_q      (rm_q)
    );

endmodule

// File: rtl/fpreg_bank_chk.sv
// Port-level temporal checks for fpreg_bank, attached by bind.
module fpreg_bank_chk #(
    parameter int AW     = 5,
    parameter int W      = 32,
    parameter int FLAG_W = 5,
    parameter int RM_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     rda_addr,
    input logic              rda_dbl,
    input logic [2*W-1:0]    rda_data,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic              wr_dbl,
    input logic [2*W-1:0]    wr_data,
    input logic              cc_we,
    input logic              cc_wdata,
    input logic              cc_q,
    input logic              flg_we,
    input logic              flg_clr,
    input logic [FLAG_W-1:0] flg_wdata,
    input logic [FLAG_W-1:0] flg_q,
    input logic              rm_we,
    input logic [RM_W-1:0]   rm_wdata,
    input logic [RM_W-1:0]   rm_q
);
    a_r1_ctl_reset: assert property (@(posedge clk)
        !rst_n |=> (cc_q == 1'b0 && flg_q == '0 && rm_q == '0));

    a_r2_sgl_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && !wr_dbl) && !rda_dbl && rda_addr == $past(wr_addr))
        |-> rda_data[W-1:0] == $past(wr_data[W-1:0]));

    a_r3_sgl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rda_dbl |-> rda_data[2*W-1:W] == '0);

    a_r5_dbl_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && wr_dbl) && rda_dbl && rda_addr[AW-1:1] == $past(wr_addr[AW-1:1]))
        |-> rda_data == $past(wr_data));

    a_r6_quiet_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $stable(rda_addr) && $stable(rda_dbl))
        |-> $stable(rda_data));

    a_r8_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_we |=> $stable(cc_q));

    a_r8_cc_load: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |=> cc_q == $past(cc_wdata));

    a_r9_flg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!flg_we && !flg_clr) |=> $stable(flg_q));

    a_r9_flg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_we && !flg_clr) |=> flg_q == ($past(flg_q) | $past(flg_wdata)));

    a_r10_flg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flg_clr |=> flg_q == ($past(flg_we) ? $past(flg_wdata) : '0));

    a_r11_rm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rm_we |=> $stable(rm_q));

    a_r11_rm_load: assert property (@(posedge clk) disable iff (!rst_n)
        rm_we |=> rm_q == $past(rm_wdata));

endmodule

bind fpreg_bank fpreg_bank_chk #(.AW(AW), .W(W), .FLAG_W(FLAG_W), .RM_W(RM_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rda_addr  (rda_addr),
    .rda_dbl   (rda_dbl),
    .rda_data  (rda_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_dbl    (wr_dbl),
    .wr_data   (wr_data),
    .cc_we     (cc_we),
    .cc_wdata  (cc_wdata),
    .cc_q      (cc_q),
    .flg_we    (flg_we),
    .flg_clr   (flg_clr),
    .flg_wdata (flg_wdata),
    .flg_q     (flg_q),
    .rm_we     (rm_we),
    .rm_wdata  (rm_wdata),
    .rm_q      (rm_q)
);

// File: tb/fpreg_bank_tb_top.sv
// Self-checking sweep bench for fpreg_bank. Inputs change at the falling
// edge; combinational reads are sampled 1 ns later.
module fpreg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rda_addr = '0, rdb_addr = '0, wr_addr = '0;
    logic        rda_dbl = 1'b0, rdb_dbl = 1'b0, wr_en = 1'b0, wr_dbl = 1'b0;
    logic [63:0] rda_data, rdb_data;
    logic [63:0] wr_data = '0;
    logic        cc_we = 1'b0, cc_wdata = 1'b0, cc_q;
    logic        flg_we = 1'b0, flg_clr = 1'b0;
    logic [4:0]  flg_wdata = '0, flg_q;
    logic        rm_we = 1'b0;
    logic [1:0]  rm_wdata = '0, rm_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model [32];

    always #10 clk = ~clk;

    fpreg_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .rda_addr(rda_addr), .rda_dbl(rda_dbl), .rda_data(rda_data),
        .rdb_addr(rdb_addr), .rdb_dbl(rdb_dbl), .rdb_data(rdb_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_dbl(wr_dbl), .wr_data(wr_data),
        .cc_we(cc_we), .cc_wdata(cc_wdata), .cc_q(cc_q),
        .flg_we(flg_we), .flg_clr(flg_clr), .flg_wdata(flg_wdata), .flg_q(flg_q),
        .rm_we(rm_we), .rm_wdata(rm_wdata), .rm_q(rm_q)
    );

    function automatic logic [31:0] pat(input int i, input int salt);
        return {8'(i + 8'h40), 8'(salt), 8'(~i), 8'(i ^ (salt * 3))};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Drive one write at the falling edge, let it take at the next rising edge.
    task automatic do_write(input logic [4:0] a, input logic dbl, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_dbl = dbl; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: everything reads zero after reset
        for (int i = 0; i < 32; i++) begin
            rda_addr = 5'(i); rda_dbl = 1'b0; rdb_addr = 5'(31 - i); rdb_dbl = 1'b0;
            #1;
            check("R1 word A", rda_data, 64'h0);
            check("R1 word B", rdb_data, 64'h0);
        end
        check("R1 ctl", {59'h0, cc_q, flg_q, rm_q} >> 0, 64'h0);

        // R2/R3/R7: single writes, one word at a time
        for (int i = 0; i < 32; i++) begin
            do_write(5'(i), 1'b0, {pat(i, 9), pat(i, 1)});
            model[i] = pat(i, 1);
            rda_addr = 5'(i); rda_dbl = 1'b0;
            rdb_addr = 5'(i ^ 1); rdb_dbl = 1'b0;
            #1;
            check("R2 target word", rda_data, {32'h0, model[i]});
            check("R2 neighbour untouched", rdb_data, {32'h0, model[i ^ 1]});
        end
        for (int i = 0; i < 32; i++) begin
            rda_addr = 5'(i); rdb_addr = 5'(31 - i); rda_dbl = 1'b0; rdb_dbl = 1'b0;
            #1;
            check("R3 port A single", rda_data, {32'h0, model[i]});
            check("R7 port B single", rdb_data, {32'h0, model[31 - i]});
        end

        // R4/R7: double reads at both addresses of every pair
        for (int a = 0; a < 32; a++) begin
            rda_addr = 5'(a); rda_dbl = 1'b1;
            rdb_addr = 5'(a); rdb_dbl = 1'b0;
            #1;
            check("R4 double read", rda_data, {model[a | 1], model[a & 30]});
            check("R7 mixed precision B", rdb_data, {32'h0, model[a]});
        end

        // R5: double writes issued at the odd address
        for (int k = 0; k < 16; k++) begin
            do_write(5'(2 * k + 1), 1'b1, {pat(k, 5), pat(k, 7)});
            model[2 * k]     = pat(k, 7);
            model[2 * k + 1] = pat(k, 5);
            rda_addr = 5'(2 * k); rda_dbl = 1'b0;
            rdb_addr = 5'(2 * k + 1); rdb_dbl = 1'b0;
            #1;
            check("R5 even word low half", rda_data, {32'h0, model[2 * k]});
            check("R5 odd word high half", rdb_data, {32'h0, model[2 * k + 1]});
            rda_addr = 5'((2 * k + 2) % 32);
            #1;
            check("R5 next pair untouched", rda_data, {32'h0, model[(2 * k + 2) % 32]});
        end

        // R6: no forwarding during the write cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd12; wr_dbl = 1'b0; wr_data = 64'h0000_0000_DEAD_BEEF;
        rda_addr = 5'd12; rda_dbl = 1'b0;
        rdb_addr = 5'd13; rdb_dbl = 1'b1;
        #1;
        check("R6 old value during write", rda_data, {32'h0, model[12]});
        check("R6 old pair during write", rdb_data, {model[13], model[12]});
        @(negedge clk);
        wr_en = 1'b0;
        model[12] = 32'hDEAD_BEEF;
        #1;
        check("R6 new value after edge", rda_data, {32'h0, model[12]});
        check("R6 new pair after edge", rdb_data, {model[13], model[12]});

        // R8: condition flag
        @(negedge clk); cc_we = 1'b1; cc_wdata = 1'b1;
        @(negedge clk); cc_we = 1'b0; cc_wdata = 1'b0; #1;
        check("R8 cc load 1", 64'(cc_q), 64'h1);
        @(negedge clk); #1;
        check("R8 cc hold", 64'(cc_q), 64'h1);
        @(negedge clk); cc_we = 1'b1; cc_wdata = 1'b0;
        @(negedge clk); cc_we = 1'b0; #1;
        check("R8 cc load 0", 64'(cc_q), 64'h0);

        // R9/R10: sticky flags and clear
        @(negedge clk); flg_we = 1'b1; flg_wdata = 5'b00101;
        @(negedge clk); flg_wdata = 5'b10000; #1;
        check("R9 first merge", 64'(flg_q), 64'h05);
        @(negedge clk); flg_we = 1'b0; flg_wdata = 5'b01010; #1;
        check("R9 second merge", 64'(flg_q), 64'h15);
        @(negedge clk); #1;
        check("R9 hold without enable", 64'(flg_q), 64'h15);
        flg_clr = 1'b1;
        @(negedge clk); flg_clr = 1'b0; #1;
        check("R10 clear alone", 64'(flg_q), 64'h00);
        flg_we = 1'b1; flg_wdata = 5'b00011;
        @(negedge clk); flg_wdata = 5'b01000; flg_clr = 1'b1; #1;
        check("R9 merge from zero", 64'(flg_q), 64'h03);
        @(negedge clk); flg_we = 1'b0; flg_clr = 1'b0; #1;
        check("R10 clear with merge", 64'(flg_q), 64'h08);

        // R11: rounding field, all values then hold
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); rm_we = 1'b1; rm_wdata = 2'(v ^ 2);
            @(negedge clk); rm_we = 1'b0; rm_wdata = 2'(v ^ 1); #1;
            check("R11 rm load", 64'(rm_q), 64'(v ^ 2));
            @(negedge clk); #1;
            check("R11 rm hold", 64'(rm_q), 64'(v ^ 2));
        end

        done = 1'b1;
        finish_run();
    end

endmodule